// File: doc/BRIEF.md
# Frame-Synced Serial Port

A full-duplex synchronous serial port for a fixed-point signal processor core. The receive and transmit sections are independent. Each has a bit clock, a frame-sync line, a shift register and a one-word buffer. A word moves on the serial side only after a falling edge of its frame sync. A control input sets the word length to 8 or 16 bits. Words are shifted most significant bit first.

The core side uses two valid/ready streams. The transmit stream writes into the one-word transmit buffer. `tx_ready` is high exactly when that buffer is empty. A held `tx_valid` therefore waits, with its data, until a frame start moves the previous word into the shift register. The receive stream presents the receive buffer. `rx_valid` stays high and `rx_data` stays stable until the consumer raises `rx_ready`.

A one-cycle interrupt pulse is raised when a transmit word enters the shift register. Another is raised when a received word lands in the buffer. The transmit bit clock comes from either an external pin or an internal divider of the core clock. The transmit frame sync is also either an input or generated by the block. Every external serial line passes through a two-flop synchronizer into the core clock domain.

Top module: `fsync_serial_port`

## Requirements
- R1: Receive frame sync and receive data are sampled at falling edges of the receive bit clock. A sample of frame sync low that follows a sample of it high starts a word while the receiver is idle. Data is then taken on the next N falling edges, MSB first.
- R2: With `cfg_long`=1, N is 16. With `cfg_long`=0, N is 8. In that case the received word sits in bits 7:0 of `rx_data` with bits 15:8 zero, and the transmitter sends `tx_data[7:0]`, MSB first.
- R3: `rx_valid` stays high with `rx_data` unchanged until `rx_ready` is seen high. A word that completes while an unread word is buffered is discarded, and the buffer keeps the older word.
- R4: `irq_rx_full` is a one-cycle pulse, given once for each word written into the receive buffer. `rx_valid` is high in that cycle.
- R5: A frame-sync falling edge that arrives while a word is still shifting is ignored, on both receive and transmit. The current word completes unchanged and no extra word results.
- R6: `tx_sdata_oe` stays low until a frame start is taken with a word waiting. The N bits are then driven at the next N rising edges of the transmit bit clock. `tx_sdata_oe` falls at the rising edge after the last bit.
- R7: `tx_ready` is high exactly when the transmit buffer is empty. An accepted word stays buffered until a frame start moves it to the shift register.
- R8: `irq_tx_empty` is a one-cycle pulse, raised when a word moves from the transmit buffer to the shift register. `tx_ready` is high in that cycle. Exactly one pulse is raised per transmitted word.
- R9: With `cfg_clk_int`=1, `tx_bclk_oe` is high and `tx_bclk_out` toggles every `cfg_div`+1 core cycles. With `cfg_clk_int`=0, `tx_bclk_out` is low and `tx_bclk_in` times the transmitter.
- R10: With `cfg_fs_gen`=0, the transmit frame sync is an input: `tx_fsync_oe` is low and `tx_fsync_out` is high. With `cfg_fs_gen`=1, `tx_fsync_oe` is high and the block drives `tx_fsync_out` low for one bit period when a word is waiting.
- R11: After reset: `tx_ready`=1, `rx_valid`=0, `tx_sdata_oe`=0, `tx_fsync_oe`=0, `tx_fsync_out`=1, and both interrupts are low.
- R12: A transmit frame-sync falling edge with no word buffered starts nothing. `tx_sdata_oe` stays low and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_long | input | 1 | 1: 16-bit words, 0: 8-bit words |
| cfg_clk_int | input | 1 | 1: transmit bit clock from internal divider |
| cfg_fs_gen | input | 1 | 1: block generates transmit frame sync |
| cfg_div | input | DIV_W | Internal bit-clock half period minus one, in core cycles |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_data | input | DATA_W | Transmit word |
| rx_valid | output | 1 | Receive buffer holds a word |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | DATA_W | Received word |
| irq_tx_empty | output | 1 | Pulse: word moved to transmit shift register |
| irq_rx_full | output | 1 | Pulse: word written to receive buffer |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Receive serial data |
| tx_bclk_in | input | 1 | External transmit bit clock |
| tx_bclk_out | output | 1 | Internal transmit bit clock |
| tx_bclk_oe | output | 1 | Enable for the transmit bit-clock driver |
| tx_fsync_in | input | 1 | External transmit frame sync |
| tx_fsync_out | output | 1 | Generated transmit frame sync |
| tx_fsync_oe | output | 1 | Enable for the transmit frame-sync driver |
| tx_sdata | output | 1 | Transmit serial data |
| tx_sdata_oe | output | 1 | Enable for the transmit data driver; low means high impedance |

## Verification
The assertions assume the following about the inputs:
- Each phase of an external serial clock lasts at least three core cycles, so the two-flop synchronizers never miss an edge.
- Frame sync and data change only near the rising edge of their bit clock.
- The configuration inputs change only while both sections are idle.

The bench keeps to these rules. Its serial clocks use a half period of five core cycles. It changes frame sync and data at the start of each high phase. It rewrites the configuration only between words, with the serial lines quiet.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // Bits per word for the selected length.
  function automatic int unsigned fsp_len(input logic lng,
                                          input int unsigned long_w,
                                          input int unsigned short_w);
    return lng ? long_w : short_w;
  endfunction

endpackage

// File: rtl/fsp_sync.sv
// Multi-stage synchronizer for one asynchronous serial line.
module fsp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {STAGES{RST_VAL}};
    else        q <= {q[STAGES-2:0], async_i};
  end

  assign level_o = q[STAGES-1];
endmodule

// File: rtl/fsp_bitclk.sv
// Internal bit-clock generator: half period of div_i+1 core cycles.
module fsp_bitclk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt;
  logic             clk_q;
  logic             wrap;

  assign wrap = en_i && (cnt == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  assign clk_o  = clk_q;
  assign rise_o = wrap && !clk_q;
  assign fall_o = wrap &&  clk_q;
endmodule

// File: rtl/fsp_rx.sv
// Receive section: frame detection, shift register, one-word buffer.
module fsp_rx
  import fsp_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_i,
  input  logic              bclk_fall_i,
  input  logic              fs_i,
  input  logic              dat_i,
  input  logic              rdy_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(DATA_W + 1);
  localparam logic [DATA_W-1:0] SHORT_MASK =
    {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic              busy;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     len;
  logic [DATA_W-2:0] sh;
  logic [DATA_W-1:0] sh_next;
  logic [DATA_W-1:0] word;
  logic              fs_prev;
  logic              done;
  logic              buf_full;
  logic [DATA_W-1:0] buf_q;
  logic              irq_q;

  assign len     = CW'(fsp_len(long_i, DATA_W, SHORT_W));
  assign sh_next = {sh, dat_i};
  assign word    = long_i ? sh_next : (sh_next & SHORT_MASK);
  assign done    = bclk_fall_i && busy && (cnt == len - 1'b1);

  // Bit-level shifting; frame edges seen while busy are ignored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      fs_prev <= 1'b1;
    end else if (bclk_fall_i) begin
      fs_prev <= fs_i;
      if (!busy) begin
        if (fs_prev && !fs_i) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else begin
        sh <= sh_next[DATA_W-2:0];
        if (cnt == len - 1'b1) busy <= 1'b0;
        else                   cnt  <= cnt + 1'b1;
      end
    end
  end

  // Buffer: a completed word is dropped when an unread word remains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (done && (!buf_full || rdy_i)) begin
        buf_full <= 1'b1;
        buf_q    <= word;
        irq_q    <= 1'b1;
      end else if (buf_full && rdy_i) begin
        buf_full <= 1'b0;
      end
    end
  end

  assign vld_o  = buf_full;
  assign data_o = buf_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/fsp_tx.sv
// Transmit section: one-word buffer, frame start, shifter, frame generator.
module fsp_tx
  import fsp_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_i,
  input  logic              fs_gen_i,
  input  logic              bclk_rise_i,
  input  logic              bclk_fall_i,
  input  logic              fs_ext_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rdy_o,
  output logic              irq_o,
  output logic              dat_o,
  output logic              dat_oe_o,
  output logic              fs_o
);
  localparam int unsigned CW = $clog2(DATA_W + 1);

  logic              buf_full;
  logic [DATA_W-1:0] buf_q;
  logic              active;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     len;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] load_word;
  logic              dat_q;
  logic              oe_q;
  logic              fs_gen_q;
  logic              fs_prev;
  logic              fs_lvl;
  logic              load;
  logic              irq_q;

  assign len       = CW'(fsp_len(long_i, DATA_W, SHORT_W));
  assign fs_lvl    = fs_gen_i ? fs_gen_q : fs_ext_i;
  assign load      = bclk_fall_i && !active && fs_prev && !fs_lvl && buf_full;
  assign load_word = long_i ? buf_q
                            : {buf_q[SHORT_W-1:0], {(DATA_W-SHORT_W){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
      active   <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      dat_q    <= 1'b0;
      oe_q     <= 1'b0;
      fs_prev  <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (vld_i && !buf_full) begin
        buf_full <= 1'b1;
        buf_q    <= data_i;
      end
      if (bclk_fall_i) fs_prev <= fs_lvl;
      if (load) begin
        active   <= 1'b1;
        cnt      <= '0;
        sh       <= load_word;
        buf_full <= 1'b0;
        irq_q    <= 1'b1;
      end
      if (bclk_rise_i && active) begin
        if (cnt == len) begin
          active <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          dat_q <= sh[DATA_W-1];
          sh    <= {sh[DATA_W-2:0], 1'b0};
          oe_q  <= 1'b1;
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  // Frame generator: low for one bit period while a word waits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fs_gen_q <= 1'b1;
    else if (!fs_gen_i)        fs_gen_q <= 1'b1;
    else if (bclk_rise_i) begin
      if (!fs_gen_q)                  fs_gen_q <= 1'b1;
      else if (!active && buf_full)   fs_gen_q <= 1'b0;
    end
  end

  assign rdy_o    = !buf_full;
  assign irq_o    = irq_q;
  assign dat_o    = dat_q;
  assign dat_oe_o = oe_q;
  assign fs_o     = fs_gen_q;
endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SHORT_W     = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_long,
  input  logic              cfg_clk_int,
  input  logic              cfg_fs_gen,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq_tx_empty,
  output logic              irq_rx_full,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              rx_sdata,
  input  logic              tx_bclk_in,
  output logic              tx_bclk_out,
  output logic              tx_bclk_oe,
  input  logic              tx_fsync_in,
  output logic              tx_fsync_out,
  output logic              tx_fsync_oe,
  output logic              tx_sdata,
  output logic              tx_sdata_oe
);
  // Lanes: 0 rx clock, 1 rx frame, 2 rx data, 3 tx clock, 4 tx frame.
  localparam int unsigned LANES   = 5;
  localparam logic [LANES-1:0] LANE_RST = 5'b10010;

  logic [LANES-1:0] raw;
  logic [LANES-1:0] lvl;
  logic             rx_clk_prev;
  logic             tx_clk_prev;
  logic             rx_fall;
  logic             ext_rise;
  logic             ext_fall;
  logic             gen_rise;
  logic             gen_fall;
  logic             gen_clk;
  logic             tx_rise;
  logic             tx_fall;

  assign raw = {tx_fsync_in, tx_bclk_in, rx_sdata, rx_fsync, rx_bclk};

  for (genvar g = 0; g < LANES; g++) begin : g_sync
    fsp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LANE_RST[g])) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw[g]),
      .level_o (lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_clk_prev <= 1'b0;
      tx_clk_prev <= 1'b0;
    end else begin
      rx_clk_prev <= lvl[0];
      tx_clk_prev <= lvl[3];
    end
  end

  assign rx_fall  =  rx_clk_prev && !lvl[0];
  assign ext_rise = !tx_clk_prev &&  lvl[3];
  assign ext_fall =  tx_clk_prev && !lvl[3];

  fsp_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cfg_clk_int),
    .div_i  (cfg_div),
    .clk_o  (gen_clk),
    .rise_o (gen_rise),
    .fall_o (gen_fall)
  );

  assign tx_rise = cfg_clk_int ? gen_rise : ext_rise;
  assign tx_fall = cfg_clk_int ? gen_fall : ext_fall;

  fsp_rx #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .long_i      (cfg_long),
    .bclk_fall_i (rx_fall),
    .fs_i        (lvl[1]),
    .dat_i       (lvl[2]),
    .rdy_i       (rx_ready),
    .vld_o       (rx_valid),
    .data_o      (rx_data),
    .irq_o       (irq_rx_full)
  );

  fsp_tx #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .long_i      (cfg_long),
    .fs_gen_i    (cfg_fs_gen),
    .bclk_rise_i (tx_rise),
    .bclk_fall_i (tx_fall),
    .fs_ext_i    (lvl[4]),
    .vld_i       (tx_valid),
    .data_i      (tx_data),
    .rdy_o       (tx_ready),
    .irq_o       (irq_tx_empty),
    .dat_o       (tx_sdata),
    .dat_oe_o    (tx_sdata_oe),
    .fs_o        (tx_fsync_out)
  );

  assign tx_bclk_out = gen_clk;
  assign tx_bclk_oe  = cfg_clk_int;
  assign tx_fsync_oe = cfg_fs_gen;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_clk_int,
  input logic              tx_bclk_out,
  input logic              tx_ready,
  input logic              irq_tx_empty,
  input logic              tx_sdata_oe,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              irq_rx_full
);
  p_rx_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_full |=> !irq_rx_full);

  p_rx_irq_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_full |-> rx_valid);

  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_tx_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |=> !irq_tx_empty);

  p_tx_ready_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |-> tx_ready);

  p_idle_at_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |-> !tx_sdata_oe);

  p_clk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk_int |=> !tx_bclk_out);
endmodule

bind fsync_serial_port fsp_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_fsync_serial_port.sv
module tb_fsync_serial_port;
  localparam int H = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_long = 1'b1, cfg_clk_int = 1'b0, cfg_fs_gen = 1'b0;
  logic [7:0]  cfg_div = 8'd2;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        irq_tx_empty, irq_rx_full;
  logic        rx_bclk = 1'b0, rx_fsync = 1'b1, rx_sdata = 1'b0;
  logic        tx_bclk_in = 1'b0, tx_fsync_in = 1'b1;
  logic        tx_bclk_out, tx_bclk_oe, tx_fsync_out, tx_fsync_oe;
  logic        tx_sdata, tx_sdata_oe;

  int n_chk = 0, n_fail = 0, irq_tx_cnt = 0, irq_rx_cnt = 0;

  always #4 clk = ~clk;

  fsync_serial_port dut (.*);

  always @(negedge clk) if (rst_n) begin
    if (irq_tx_empty) irq_tx_cnt++;
    if (irq_rx_full)  irq_rx_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int nbits(input logic lng);
    return lng ? 16 : 8;
  endfunction

  function automatic logic bit_at(input logic [15:0] d, input logic lng, input int i);
    return lng ? d[15-i] : d[7-i];
  endfunction

  function automatic logic [15:0] exp_rx(input logic [15:0] d, input logic lng);
    return lng ? d : {8'h00, d[7:0]};
  endfunction

  function automatic logic [15:0] exp_tx(input logic [15:0] d, input logic lng);
    return lng ? d : {8'h00, d[7:0]};
  endfunction

  // One receive bit period: lines change as the clock rises.
  task automatic rx_hi(input logic fs, input logic d);
    @(negedge clk); rx_bclk = 1'b1; rx_fsync = fs; rx_sdata = d;
    repeat (H) @(negedge clk);
    rx_bclk = 1'b0;
    repeat (H-1) @(negedge clk);
  endtask

  task automatic rx_send(input logic [15:0] d, input logic lng, input logic glitch);
    rx_hi(1'b1, 1'b0); rx_hi(1'b1, 1'b0); rx_hi(1'b0, 1'b0);
    for (int i = 0; i < nbits(lng); i++)
      rx_hi((glitch && i == 3) ? 1'b0 : 1'b1, bit_at(d, lng, i));
    rx_hi(1'b1, 1'b0); rx_hi(1'b1, 1'b0);
  endtask

  task automatic rx_take(input logic [15:0] exp, input string tag);
    @(negedge clk);
    chk({tag, " rx_valid"}, rx_valid, 1);
    chk({tag, " rx_data"}, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    @(negedge clk);
    chk({tag, " drained"}, rx_valid, 0);
  endtask

  // One transmit bit period; data sampled at the end of the high phase.
  task automatic tx_hi(input logic fs, output logic d, output logic oe);
    @(negedge clk); tx_bclk_in = 1'b1; tx_fsync_in = fs;
    repeat (H) @(negedge clk);
    d = tx_sdata; oe = tx_sdata_oe;
    tx_bclk_in = 1'b0;
    repeat (H-1) @(negedge clk);
  endtask

  task automatic tx_push(input logic [15:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic tx_ext_word(input logic [15:0] d, input logic lng, input logic glitch,
                             input string tag);
    int   c0;
    logic b, oe, all_oe;
    logic [15:0] got;
    c0 = irq_tx_cnt;
    chk({tag, " R7 ready before"}, tx_ready, 1);
    tx_push(d);
    chk({tag, " R7 held"}, tx_ready, 0);
    tx_hi(1'b1, b, oe); chk({tag, " R6 undriven"}, oe, 0);
    tx_hi(1'b1, b, oe); chk({tag, " R6 undriven"}, oe, 0);
    chk({tag, " R8 no early irq"}, irq_tx_cnt, c0);
    tx_hi(1'b0, b, oe); chk({tag, " R6 undriven at frame"}, oe, 0);
    got = '0; all_oe = 1'b1;
    for (int i = 0; i < nbits(lng); i++) begin
      tx_hi((glitch && i == 3) ? 1'b0 : 1'b1, b, oe);
      got = {got[14:0], b};
      all_oe = all_oe & oe;
    end
    chk({tag, " R6 driven"}, all_oe, 1);
    chk({tag, " R2 R5 bits"}, got, exp_tx(d, lng));
    tx_hi(1'b1, b, oe);
    chk({tag, " R6 released"}, oe, 0);
    chk({tag, " R8 one irq"}, irq_tx_cnt, c0 + 1);
    chk({tag, " R7 ready after"}, tx_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic b, oe, prev, saw_fs, fs_first;
    int   c, nrec, gap, seed;
    logic [15:0] got, d;
    logic lng;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 tx_ready", tx_ready, 1);
    chk("R11 rx_valid", rx_valid, 0);
    chk("R11 tx_sdata_oe", tx_sdata_oe, 0);
    chk("R11 irqs", {irq_tx_empty, irq_rx_full}, 0);
    chk("R10 fs input oe", tx_fsync_oe, 0);
    chk("R10 fs out idle", tx_fsync_out, 1);

    // R1 R4: 16-bit receive
    c = irq_rx_cnt;
    rx_send(16'hA5C3, 1'b1, 1'b0);
    chk("R4 one irq", irq_rx_cnt, c + 1);
    rx_take(16'hA5C3, "R1 rx16");

    // R2: 8-bit receive
    cfg_long = 1'b0;
    rx_send(16'hFF96, 1'b0, 1'b0);
    rx_take(exp_rx(16'hFF96, 1'b0), "R2 rx8");
    cfg_long = 1'b1;

    // R5: frame edge mid-word on receive
    c = irq_rx_cnt;
    rx_send(16'h1E0F, 1'b1, 1'b1);
    chk("R5 rx single word", irq_rx_cnt, c + 1);
    rx_take(16'h1E0F, "R5 rx glitch");

    // R3: overrun keeps the older word
    rx_send(16'h1234, 1'b1, 1'b0);
    c = irq_rx_cnt;
    rx_send(16'h5678, 1'b1, 1'b0);
    chk("R3 dropped no irq", irq_rx_cnt, c);
    chk("R3 held valid", rx_valid, 1);
    rx_take(16'h1234, "R3 older kept");

    // R6 R7 R8: external clock and frame
    tx_ext_word(16'hC3A5, 1'b1, 1'b0, "R6 tx16");
    cfg_long = 1'b0;
    tx_ext_word(16'h7E81, 1'b0, 1'b0, "R2 tx8");
    cfg_long = 1'b1;
    tx_ext_word(16'h0FF0, 1'b1, 1'b1, "R5 tx glitch");

    // R12: frame with nothing buffered
    c = irq_tx_cnt;
    tx_hi(1'b1, b, oe); tx_hi(1'b0, b, oe);
    tx_hi(1'b1, b, oe); tx_hi(1'b1, b, oe);
    chk("R12 no drive", oe, 0);
    chk("R12 no irq", irq_tx_cnt, c);

    // R9 R10: internal clock and generated frame
    cfg_clk_int = 1'b1; cfg_fs_gen = 1'b1; cfg_div = 8'd2;
    repeat (4) @(negedge clk);
    chk("R9 clk oe", tx_bclk_oe, 1);
    chk("R10 fs oe", tx_fsync_oe, 1);
    prev = tx_bclk_out;
    while (tx_bclk_out == prev) @(negedge clk);
    prev = tx_bclk_out; gap = 0;
    while (tx_bclk_out == prev) begin @(negedge clk); gap++; end
    chk("R9 half period", gap, 3);

    c = irq_tx_cnt;
    tx_push(16'hB00B);
    got = '0; nrec = 0; saw_fs = 1'b0; fs_first = 1'b0;
    prev = tx_bclk_out;
    for (int k = 0; k < 3000 && nrec < 16; k++) begin
      @(negedge clk);
      if (!tx_fsync_out) saw_fs = 1'b1;
      if (prev && !tx_bclk_out && tx_sdata_oe) begin
        if (nrec == 0) fs_first = saw_fs;
        got = {got[14:0], tx_sdata};
        nrec++;
      end
      prev = tx_bclk_out;
    end
    chk("R10 frame before data", fs_first, 1);
    chk("R9 internal bits", got, 16'hB00B);
    repeat (20) @(negedge clk);
    chk("R6 internal released", tx_sdata_oe, 0);
    chk("R8 internal irq", irq_tx_cnt, c + 1);
    chk("R10 frame returns high", tx_fsync_out, 1);

    cfg_clk_int = 1'b0; cfg_fs_gen = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 fs back to input", tx_fsync_oe, 0);
    chk("R9 clk quiet", tx_bclk_out, 0);

    // Random words, both directions
    seed = $urandom(32'h5EED);
    for (int n = 0; n < 6; n++) begin
      d = 16'($urandom);
      lng = 1'($urandom % 2);
      cfg_long = lng;
      rx_send(d, lng, 1'b0);
      rx_take(exp_rx(d, lng), "R1 R2 random rx");
      tx_ext_word(d ^ 16'h5A5A, lng, 1'b0, "R6 R2 random tx");
    end

    finish_run();
  end
endmodule